// File: doc/BRIEF.md
# Field-Masked Control Register Pair

This block keeps a 64-bit translation-control register beside a 64-bit lock register. Each implemented lock bit, when set, freezes a whole field of the control register against ordinary software writes; the fields whose lock bit is clear take the new write data. A lock bit always sits at the lowest bit of the field it guards, and the field width is fixed per position. Examples are a 6-bit size field at bit 0, a 3-bit address-size field at bit 32, and 2-bit attribute fields at even positions between 8 and 30.

The lock register is protected by privilege level. The highest level (3) may always rewrite it. The hypervisor level (2) may write it only while it holds zero, so a single nonzero value set there locks the register against that level from then on. Lower levels may never write it. Any refused write leaves both registers as they were and raises a one-cycle `undef` strobe.

Reads are combinational: `reg_sel` chooses which register appears on `rdata`.

Top module: `fmask_ctl_pair`

## Requirements
- R1: While reset is asserted and just after it, both registers read as zero and `undef` is low.
- R2: With the lock register at zero, a control write from level 1, 2 or 3 stores all 64 bits of `wdata`.
- R3: A set lock bit at position b keeps control bits b up to b+w-1 unchanged on writes from level 1 or 2. Here w is 6 for b = 0 and b = 16, 3 for b = 32, 2 for b in {8,10,12,14,24,26,28,30}, and 1 otherwise.
- R4: Control bits 6, 35, 62 and 63 have no guard and always take write data on an accepted control write. So does any field whose lock bit is clear.
- R5: Implemented lock bits are 0, 7, 8, 10, 12, 14, 16, 22, 23, 24, 26, 28, 30, 32 and 36 to 61. All other lock bits read as zero and ignore writes, and they do not count toward the nonzero lock test.
- R6: A lock write from level 2 while the lock register is zero is accepted and leaves `undef` low.
- R7: A lock write from level 2 while the lock register is nonzero is refused. The lock register is unchanged and `undef` is raised.
- R8: A lock write from level 3 is always accepted, whatever the current lock value.
- R9: A lock write from level 0 or 1 is refused, and so is a control write from level 0. The target register is unchanged and `undef` is raised.
- R10: A control write from level 3 ignores the lock register and stores all of `wdata`.
- R11: `undef` goes high in the cycle after the edge that refused a write and stays high for exactly one cycle. It stays low when no write is refused.
- R12: `rdata` shows the control register when `reg_sel` is 0 and the lock register when `reg_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for the selected register |
| reg_sel | input | 1 | 0 selects the control register, 1 selects the lock register |
| priv | input | 2 | Privilege level of the access, 0 to 3 |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Selected register contents |
| undef | output | 1 | One-cycle strobe for a refused write |

## Verification
A wrong lock value shows up on `rdata` in the same cycle as the read. One control write later it also shows as guarded fields that move or free fields that stay frozen. A wrong lock decision shows one cycle after the write edge, both as a wrong `undef` level and as a lock register that changed when it should not have, or the reverse. The multi-bit guard widths matter most: one write of all ones followed by one write of zeros exposes every misplaced field boundary in a single read.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

   localparam int unsigned FMC_REG_W = 64;

   typedef enum logic [1:0] {
      LVL_APP  = 2'd0,
      LVL_KERN = 2'd1,
      LVL_HYP  = 2'd2,
      LVL_TOP  = 2'd3
   } lvl_e;

   // true when bit b of the lock register is implemented
   function automatic bit guard_present(int unsigned b);
      return (b == 0) || (b == 7) ||
             (b >= 8  && b <= 16 && (b % 2) == 0) ||
             (b == 22) || (b == 23) ||
             (b >= 24 && b <= 32 && (b % 2) == 0) ||
             (b >= 36 && b <= 61);
   endfunction

   // span of the control field guarded by lock bit b
   function automatic int unsigned guard_width(int unsigned b);
      case (b)
         0, 16:                          return 6;
         32:                             return 3;
         8, 10, 12, 14, 24, 26, 28, 30:  return 2;
         default:                        return 1;
      endcase
   endfunction

   function automatic logic [FMC_REG_W-1:0] implemented_bits();
      logic [FMC_REG_W-1:0] v;
      v = '0;
      for (int b = 0; b < FMC_REG_W; b++)
         v[b] = guard_present(b);
      return v;
   endfunction

   function automatic logic [FMC_REG_W-1:0] spread_guard(logic [FMC_REG_W-1:0] m);
      logic [FMC_REG_W-1:0] g;
      g = '0;
      for (int b = 0; b < FMC_REG_W; b++)
         if (guard_present(b) && m[b])
            for (int k = 0; k < 6; k++)
               if (k < int'(guard_width(b)) && (b + k) < FMC_REG_W)
                  g[b+k] = 1'b1;
      return g;
   endfunction

endpackage

// File: rtl/fmc_guard_expand.sv
module fmc_guard_expand #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] lock_i,
   output logic [W-1:0] guard_o
);
   // each implemented lock bit fans out over its field
   always_comb begin
      guard_o = '0;
      for (int b = 0; b < int'(W); b++) begin
         if (fmc_pkg::guard_present(b) && lock_i[b]) begin
            for (int k = 0; k < 6; k++) begin
               if (k < int'(fmc_pkg::guard_width(b)) && (b + k) < int'(W))
                  guard_o[b+k] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/fmc_lock_reg.sv
module fmc_lock_reg #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [1:0]   lvl_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] lock_o,
   output logic         refuse_o
);
   import fmc_pkg::*;

   localparam logic [W-1:0] IMPL = W'(implemented_bits());

   logic [W-1:0] lock_q;
   logic         accept;

   always_comb begin
      accept   = 1'b0;
      refuse_o = 1'b0;
      if (wr_i) begin
         case (lvl_e'(lvl_i))
            LVL_TOP: accept = 1'b1;
            LVL_HYP: begin
               if (lock_q == '0) accept   = 1'b1;
               else              refuse_o = 1'b1;
            end
            default: refuse_o = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lock_q <= '0;
      else if (accept) lock_q <= wdata_i & IMPL;
   end

   assign lock_o = lock_q;
endmodule

// File: rtl/fmc_ctrl_reg.sv
module fmc_ctrl_reg #(
   parameter int unsigned W          = 64,
   parameter bit          TOP_BYPASS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [1:0]   lvl_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] guard_i,
   output logic [W-1:0] ctrl_o,
   output logic         refuse_o
);
   import fmc_pkg::*;

   logic [W-1:0] ctrl_q;
   logic [W-1:0] eff_guard;
   logic         accept;

   generate
      if (TOP_BYPASS) begin : g_bypass
         assign eff_guard = (lvl_e'(lvl_i) == LVL_TOP) ? '0 : guard_i;
      end else begin : g_strict
         assign eff_guard = guard_i;
      end
   endgenerate

   assign refuse_o = wr_i && (lvl_e'(lvl_i) == LVL_APP);
   assign accept   = wr_i && !refuse_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (accept) ctrl_q <= (ctrl_q & eff_guard) | (wdata_i & ~eff_guard);
   end

   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/fmask_ctl_pair.sv
module fmask_ctl_pair #(
   parameter int unsigned REG_W      = 64,
   parameter int unsigned LVL_W      = 2,
   parameter bit          TOP_BYPASS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             reg_sel,
   input  logic [LVL_W-1:0] priv,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             undef
);
   generate
      if (REG_W != fmc_pkg::FMC_REG_W) begin : g_bad_width
         $error("fmask_ctl_pair: REG_W must equal the field map width");
      end
      if (LVL_W != 2) begin : g_bad_lvl
         $error("fmask_ctl_pair: LVL_W must be 2");
      end
   endgenerate

   logic [REG_W-1:0] ctrl_q;
   logic [REG_W-1:0] mask_q;
   logic [REG_W-1:0] guard;
   logic             ctrl_ref;
   logic             lock_ref;
   logic             undef_q;

   fmc_guard_expand #(.W(REG_W)) u_expand (
      .lock_i  (mask_q),
      .guard_o (guard)
   );

   fmc_lock_reg #(.W(REG_W)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_en && reg_sel),
      .lvl_i    (priv),
      .wdata_i  (wdata),
      .lock_o   (mask_q),
      .refuse_o (lock_ref)
   );

   fmc_ctrl_reg #(.W(REG_W), .TOP_BYPASS(TOP_BYPASS)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_en && !reg_sel),
      .lvl_i    (priv),
      .wdata_i  (wdata),
      .guard_i  (guard),
      .ctrl_o   (ctrl_q),
      .refuse_o (ctrl_ref)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) undef_q <= 1'b0;
      else        undef_q <= lock_ref | ctrl_ref;
   end

   assign undef = undef_q;
   assign rdata = reg_sel ? mask_q : ctrl_q;
endmodule

// File: rtl/fmc_pair_chk.sv
module fmc_pair_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        reg_sel,
   input logic [1:0]  priv,
   input logic [63:0] wdata,
   input logic [63:0] ctrl_q,
   input logic [63:0] mask_q,
   input logic        undef
);
   localparam logic [63:0] IMPL = fmc_pkg::implemented_bits();

   logic [63:0] guard_now;
   assign guard_now = fmc_pkg::spread_guard(mask_q);

   // R3: guarded fields hold on level 1/2 control writes
   a_r3_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !reg_sel && (priv == 2'd1 || priv == 2'd2)
      |=> ((ctrl_q ^ $past(ctrl_q)) & $past(guard_now)) == '0);

   // R5: unimplemented lock bits stay zero
   a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q & ~IMPL) == '0);

   // R7: locked register refuses a level 2 write
   a_r7_locked_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && reg_sel && priv == 2'd2 && mask_q != '0
      |=> $stable(mask_q) && undef);

   // R8: top level lock write always lands
   a_r8_top_lock: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && reg_sel && priv == 2'd3
      |=> mask_q == ($past(wdata) & IMPL) && !undef);

   // R9: low levels are refused
   a_r9_low_lock: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && reg_sel && priv < 2'd2 |=> $stable(mask_q) && undef);

   a_r9_app_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !reg_sel && priv == 2'd0 |=> $stable(ctrl_q) && undef);

   // R11: no write, no strobe
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !undef);
endmodule

bind fmask_ctl_pair fmc_pair_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .reg_sel (reg_sel),
   .priv    (priv),
   .wdata   (wdata),
   .ctrl_q  (ctrl_q),
   .mask_q  (mask_q),
   .undef   (undef)
);

// File: tb/sim_fmask_ctl_pair.sv
`timescale 1ns/1ps
module sim_fmask_ctl_pair;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic        reg_sel;
   logic [1:0]  priv;
   logic [63:0] wdata;
   logic [63:0] rdata;
   logic        undef;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   fmask_ctl_pair u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
      .priv(priv), .wdata(wdata), .rdata(rdata), .undef(undef)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic [1:0]  lvl;
      logic        sel;
      logic [63:0] data;
      logic [63:0] ectl;
      logic [63:0] emsk;
      logic        eund;
   } step_t;

   localparam int NSTEP = 14;
   localparam step_t TBL [NSTEP] = '{
      '{8'd2,  2'd1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0},                   // R2
      '{8'd6,  2'd2, 1'b1, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0},                   // R6
      '{8'd3,  2'd1, 1'b0, 64'h0, 64'h0000_0000_0000_003F, 64'h1, 1'b0},                                     // R3
      '{8'd7,  2'd2, 1'b1, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_003F, 64'h1, 1'b1},                   // R7
      '{8'd9,  2'd0, 1'b1, 64'h0, 64'h0000_0000_0000_003F, 64'h1, 1'b1},                                     // R9
      '{8'd8,  2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_003F, 64'h3FFF_FFF1_55C1_5581, 1'b0}, // R8 R5
      '{8'd4,  2'd2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hC000_0008_0000_007F, 64'h3FFF_FFF1_55C1_5581, 1'b0}, // R4
      '{8'd9,  2'd0, 1'b0, 64'h0, 64'hC000_0008_0000_007F, 64'h3FFF_FFF1_55C1_5581, 1'b1},                   // R9
      '{8'd10, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h3FFF_FFF1_55C1_5581, 1'b0}, // R10
      '{8'd8,  2'd3, 1'b1, 64'h0, 64'h0123_4567_89AB_CDEF, 64'h0, 1'b0},                                     // R8
      '{8'd5,  2'd2, 1'b1, 64'hC000_0000_0000_0002, 64'h0123_4567_89AB_CDEF, 64'h0, 1'b0},                   // R5
      '{8'd6,  2'd2, 1'b1, 64'h0000_0000_0000_0400, 64'h0123_4567_89AB_CDEF, 64'h400, 1'b0},                 // R6
      '{8'd3,  2'd2, 1'b0, 64'h0, 64'h0000_0000_0000_0C00, 64'h400, 1'b0},                                   // R3
      '{8'd9,  2'd1, 1'b1, 64'h0, 64'h0000_0000_0000_0C00, 64'h400, 1'b1}                                    // R9
   };

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic read_both(string tag, logic [63:0] ectl, logic [63:0] emsk);
      reg_sel = 1'b0; #1;
      chk({tag, " ctrl (R12)"}, rdata, ectl);
      reg_sel = 1'b1; #1;
      chk({tag, " lock (R12)"}, rdata, emsk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; reg_sel = 1'b0; priv = 2'd0; wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      read_both("R1 in reset", 64'h0, 64'h0);
      chk("R1 undef in reset", {63'd0, undef}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      read_both("R1 after reset", 64'h0, 64'h0);

      for (int i = 0; i < NSTEP; i++) begin
         string tag;
         tag = $sformatf("R%0d step %0d", TBL[i].req, i);
         @(negedge clk);
         wr_en = 1'b1; priv = TBL[i].lvl; reg_sel = TBL[i].sel; wdata = TBL[i].data;
         @(posedge clk);
         @(negedge clk);
         wr_en = 1'b0;
         chk({tag, " undef (R11)"}, {63'd0, undef}, {63'd0, TBL[i].eund});
         read_both(tag, TBL[i].ectl, TBL[i].emsk);
         if (TBL[i].eund) begin
            @(negedge clk);
            chk({tag, " R11 strobe one cycle"}, {63'd0, undef}, 64'h0);
         end
      end

      // R11: idle cycles produce no strobe
      @(negedge clk);
      @(negedge clk);
      chk("R11 idle", {63'd0, undef}, 64'h0);

      // R1: reset mid-run clears both registers
      rst_n = 1'b0;
      #1;
      read_both("R1 reset again", 64'h0, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule